// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block turns four active-low external interrupt pins into four interrupt request lines. An 8-bit control register, written and read over a simple bus port, selects how each channel works. A 0 in the channel's mode bit means level sensing: the request is active while the pin is low. A 1 means edge sensing: a high-to-low transition on the pin latches a request. That request stays active until the interrupt handler sends an acknowledge pulse for the channel.

Every pin first passes through a two-flop synchronizer. A third flop keeps the previous synchronized value, and the falling-edge detector compares the two. Each channel has a small two-state machine that holds the latched request. Its states are `CH_IDLE` (no latched request) and `CH_PEND` (a latched request is waiting). The transitions are:
- *capture*: `CH_IDLE`→`CH_PEND` on a detected falling edge in edge mode.
- *acknowledge*: `CH_PEND`→`CH_IDLE` on an acknowledge pulse with no new edge in that cycle.
- *mode flush*: any state→`CH_IDLE` when the channel's mode bit differs from the value it had on the previous clock, or when the standby input is high.

Channels 0, 1, 2 and 3 take their mode from register bits 0, 1, 4 and 5. The other four register bits are plain storage.

Top module: `irq_sense_ctrl`

## Requirements
- R1: The control register holds 8 bits. A write (`bus_wr` high) loads `bus_wdata` at the next rising clock edge. `bus_rdata` always shows all 8 stored bits, and reading changes nothing.
- R2: Reset (`rst_n` low) clears the register to 0x00, clears all latched requests and sets the synchronizers to the idle-high value. While `standby` is high, the same clear happens at every clock edge.
- R3: `irq_req[0]`, `irq_req[1]`, `irq_req[2]` and `irq_req[3]` belong to `pin_n[0..3]` and take their mode from register bits 0, 1, 4 and 5 in that order.
- R4: In level mode (mode bit 0), `irq_req[i]` equals the inverse of `pin_n[i]` delayed by the two synchronizer flops, with no latching.
- R5: In edge mode (mode bit 1), a pin going from 1 to 0 makes `irq_req[i]` go high after the third rising edge that follows the change, and it stays high.
- R6: An acknowledge pulse `irq_ack[i]` clears a latched edge request at the next edge. If a new falling edge is detected in the same cycle, the request stays set.
- R7: Register bits 7, 6, 3 and 2 read back as written but never change any request output.
- R8: When a channel's mode bit changes, that channel's latched request is discarded at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Hardware standby; clears all state while high |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data |
| pin_n | input | 4 | Active-low external interrupt pins |
| irq_ack | input | 4 | Per-channel acknowledge pulses |
| irq_req | output | 4 | Per-channel interrupt requests |

## Verification
The case that is hardest to reach is an acknowledge that lands in the exact cycle in which a new falling edge is detected. Edge detection sits three flops behind the pin, so the two events only line up if the stimulus is timed against that pipeline. The bench handles this in two ways. It drives a fall, waits two edges and pulses the acknowledge. It also runs a long random phase with frequent pin toggles and acknowledges. A second hard case is a mode write while a request is latched. The bench latches edges first and then rewrites the mode bits, and a behavioural reference model checks every cycle.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_e;

    // Channel index to control-register bit: 0,1,4,5,...
    function automatic int unsigned chan_bit(input int unsigned ch);
        return (ch / 2) * 4 + (ch % 2);
    endfunction

endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         standby,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (standby) begin
            q_r <= '0;
        end else if (wr_i) begin
            q_r <= wdata_i;
        end
    end

    assign q_o = q_r;

    AST_STANDBY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (q_o == '0)); // R2

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !standby) |=> (q_o == $past(wdata_i))); // R1

    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !standby) |=> $stable(q_o)); // R1

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic pin_i,
    output logic sync_o,
    output logic fall_o
);

    logic stage1_q, stage2_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= 1'b1;
            stage2_q <= 1'b1;
            prev_q   <= 1'b1;
        end else if (standby) begin
            stage1_q <= 1'b1;
            stage2_q <= 1'b1;
            prev_q   <= 1'b1;
        end else begin
            stage1_q <= pin_i;
            stage2_q <= stage1_q;
            prev_q   <= stage2_q;
        end
    end

    assign sync_o = stage2_q;
    assign fall_o = prev_q & ~stage2_q;

endmodule

// File: rtl/irq_chan_fsm.sv
module irq_chan_fsm
    import irq_sense_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic mode_i,   // 0 level, 1 falling edge
    input  logic sync_i,
    input  logic fall_i,
    input  logic ack_i,
    output logic req_o
);

    ch_state_e state_q, state_d;
    logic      mode_seen_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (mode_i != mode_seen_q) begin
            state_d = CH_IDLE;                       // mode flush
        end else begin
            unique case (state_q)
                CH_IDLE: if (mode_i && fall_i) state_d = CH_PEND;   // capture
                CH_PEND: if (ack_i && !fall_i) state_d = CH_IDLE;   // acknowledge
                default: state_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= CH_IDLE;
            mode_seen_q <= 1'b0;
        end else if (standby) begin
            state_q     <= CH_IDLE;
            mode_seen_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            mode_seen_q <= mode_i;
        end
    end

    // outputs
    always_comb begin
        if (mode_i) req_o = (state_q == CH_PEND);
        else        req_o = ~sync_i;
    end

    AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !mode_seen_q) |-> (state_q == CH_IDLE)); // R4

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PEND && !ack_i && !standby && mode_i == mode_seen_q)
        |=> (state_q == CH_PEND)); // R5

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PEND && ack_i && !fall_i && !standby) |=> (state_q == CH_IDLE)); // R6

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && mode_seen_q && fall_i && !standby) |=> (state_q == CH_PEND)); // R6

    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_seen_q) |=> (state_q == CH_IDLE)); // R8

endmodule

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_sense_pkg::*;
#(
    parameter int unsigned NCH   = 4,
    parameter int unsigned REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic [NCH-1:0]   pin_n,
    input  logic [NCH-1:0]   irq_ack,
    output logic [NCH-1:0]   irq_req
);

    localparam int unsigned TOP_BIT = chan_bit(NCH - 1);

    logic [REG_W-1:0] ctrl_q;
    logic [NCH-1:0]   sync_w, fall_w;

    irq_ctrl_reg #(.W(REG_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .standby (standby),
        .wr_i    (bus_wr),
        .wdata_i (bus_wdata),
        .q_o     (ctrl_q)
    );

    assign bus_rdata = ctrl_q;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        localparam int unsigned MBIT = chan_bit(g);

        irq_pin_sync sync_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .standby (standby),
            .pin_i   (pin_n[g]),
            .sync_o  (sync_w[g]),
            .fall_o  (fall_w[g])
        );

        irq_chan_fsm fsm_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .standby (standby),
            .mode_i  (ctrl_q[MBIT]),
            .sync_i  (sync_w[g]),
            .fall_i  (fall_w[g]),
            .ack_i   (irq_ack[g]),
            .req_o   (irq_req[g])
        );

        AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl_q[MBIT] |-> (irq_req[g] == ~sync_w[g])); // R3
    end

    initial begin
        AST_MAP_FITS: assert (TOP_BIT < REG_W); // R3
    end

endmodule

// File: tb/irq_sense_ctrl_tb.sv
module irq_sense_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [3:0] pin_n = 4'hF;
    logic [3:0] irq_ack = 4'h0;
    logic [3:0] irq_req;

    int vectors = 0;
    int miscompares = 0;
    bit checking = 1'b0;
    string cur_req = "R2";

    // reference model state
    logic [7:0] m_reg;
    bit m_s1[NCH], m_s2[NCH], m_prev[NCH], m_flag[NCH], m_seen[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sense_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_n(pin_n), .irq_ack(irq_ack), .irq_req(irq_req)
    );

    function automatic int mbit(input int ch);
        return (ch / 2) * 4 + (ch % 2);
    endfunction

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n || standby) begin
            m_reg = 8'h00;
            for (int c = 0; c < NCH; c++) begin
                m_s1[c] = 1; m_s2[c] = 1; m_prev[c] = 1; m_flag[c] = 0; m_seen[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit mode, fall;
                mode = m_reg[mbit(c)];
                fall = m_prev[c] && !m_s2[c];
                if (mode != m_seen[c])      m_flag[c] = 0;
                else if (mode && fall)      m_flag[c] = 1;
                else if (irq_ack[c] && !fall) m_flag[c] = 0;
                m_seen[c] = mode;
                m_prev[c] = m_s2[c];
                m_s2[c]   = m_s1[c];
                m_s1[c]   = pin_n[c];
            end
            if (bus_wr) m_reg = bus_wdata;
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (checking) begin
            logic [3:0] exp_req;
            for (int c = 0; c < NCH; c++)
                exp_req[c] = m_reg[mbit(c)] ? m_flag[c] : !m_s2[c];
            vectors++;
            if (bus_rdata !== m_reg) begin
                miscompares++;
                $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, bus_rdata, m_reg, $time);
            end
            vectors++;
            if (irq_req !== exp_req) begin
                miscompares++;
                $display("FAIL %s irq_req actual=%b expected=%b t=%0t", cur_req, irq_req, exp_req, $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rand_run(input int n, input int ack_on);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            pin_n   = 4'($urandom);
            irq_ack = ack_on ? 4'($urandom & $urandom) : 4'h0;
        end
        @(negedge clk);
        irq_ack = 4'h0;
    endtask

    initial begin
        // R2: reset state
        cycles(3);
        rst_n = 1'b1;
        @(posedge clk);
        checking = 1'b1;
        cycles(4);

        // R1: write/read back
        cur_req = "R1";
        write_reg(8'h5A); cycles(2);
        write_reg(8'hFF); cycles(2);
        write_reg(8'h00); cycles(2);

        // R4: level mode, varied pin patterns
        cur_req = "R4";
        rand_run(40, 0);
        pin_n = 4'h0; cycles(5);
        pin_n = 4'hF; cycles(5);

        // R7: only reserved bits set, still level behaviour
        cur_req = "R7";
        write_reg(8'hCC);
        rand_run(40, 0);
        pin_n = 4'hF; cycles(4);

        // R3: one channel in edge mode at a time
        cur_req = "R3";
        foreach (mbit_list[i]) begin
            write_reg(mbit_list[i]);
            rand_run(20, 0);
            pin_n = 4'hF; cycles(4);
        end

        // R5: edge capture and stickiness
        cur_req = "R5";
        write_reg(8'h33);
        cycles(3);
        pin_n = 4'h0; cycles(2);
        pin_n = 4'hF; cycles(10);

        // R6: acknowledge, then edge coincident with ack
        cur_req = "R6";
        irq_ack = 4'hF; cycles(1); irq_ack = 4'h0; cycles(3);
        pin_n = 4'h0;           // fall reaches detector two edges later
        cycles(2);
        irq_ack = 4'hF;         // same cycle as detected fall
        cycles(1);
        irq_ack = 4'h0; pin_n = 4'hF; cycles(4);
        rand_run(300, 1);
        pin_n = 4'hF; cycles(4);

        // R8: mode change drops latched requests
        cur_req = "R8";
        pin_n = 4'h0; cycles(4); pin_n = 4'hF; cycles(4);
        write_reg(8'h00); cycles(2);
        write_reg(8'h33); cycles(4);
        pin_n = 4'h0; cycles(4); pin_n = 4'hF; cycles(4);
        write_reg(8'h11); cycles(4);
        rand_run(60, 1);
        for (int k = 0; k < 20; k++) begin
            write_reg(8'($urandom));
            rand_run(8, 1);
        end

        // R2: standby clears register and pending flags
        cur_req = "R2";
        write_reg(8'hF3);
        pin_n = 4'h0; cycles(4); pin_n = 4'hF; cycles(2);
        standby = 1'b1; cycles(3);
        standby = 1'b0; cycles(4);
        pin_n = 4'h0; cycles(4);
        pin_n = 4'hF; cycles(4);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    logic [7:0] mbit_list [4] = '{8'h01, 8'h02, 8'h10, 8'h20};

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule